// File: doc/BRIEF.md
# Incremental Rule Pattern Matcher

This block matches a stream of facts against a small set of configured rules and keeps the matching work incremental. A fact is a tuple of one 8-bit predicate code and two 8-bit arguments. Every fact enters through one input port. It is tested against the constant fields of every premise of every rule. When a fact satisfies a premise, the variable bindings it produces are stored in that premise's alpha memory. A join stage then combines the new fact only with results already stored. For a three-premise rule, the joined first-and-second premise pairs are kept in a beta memory. A later fact is checked only against this stored state, so the whole fact history is never rescanned.

Rules are loaded through a plain register write port. Each of the four rules has up to three premises. Every argument field of a premise is either a constant to compare, a reference to one of two variable slots, or a wildcard. A rule is activated when all of its enabled premises are satisfied by facts that agree on every shared variable. The activated rules form a sticky 4-bit conflict mask.

Facts use a valid/ready handshake. A fact is taken on any rising edge where `fact_valid` and `fact_ready` are both high. `fact_ready` then stays low while the joins for that fact run. The sender must hold the fact and `fact_valid` stable until the fact is taken. When the joins finish, `match_done` pulses for one cycle, and `conflict_mask` already shows the result of that fact.

Top module: `rete_matcher`

## Requirements
- R1: `fact_ready` is high only while the block is idle. After a fact is taken, `fact_ready` is low until `match_done` has pulsed. `match_done` is high for exactly one cycle. It is first seen on the 2*DEPTH+2nd falling edge after the accepting rising edge, where the first falling edge after acceptance counts as one (18 with DEPTH = 8).
- R2: A premise is configured by writing `cfg_wdata` with `cfg_we` high. The address is `cfg_addr` = {rule[1:0], premise[1:0]}, and premise index 3 is ignored. The data word holds these fields:
  - bit 28: enable
  - bits 27:20: predicate
  - bits 19:18: kind of argument 0
  - bits 17:10: constant for argument 0
  - bits 9:8: kind of argument 1
  - bits 7:0: constant for argument 1
- R3: Argument kinds are 0 = must equal the constant, 1 = bind variable slot 0, 2 = bind variable slot 1, and 3 = wildcard. A fact satisfies a premise only if the premise is enabled, the predicate is equal, and every constant-kind argument is equal.
- R4: If both arguments of one premise name the same variable slot, the fact satisfies that premise only when the two argument values are equal.
- R5: A rule whose only enabled premise is premise 0 is activated by the first fact that satisfies it.
- R6: A multi-premise rule is activated only when the facts that satisfy its premises bind every shared variable to the same value. Facts with inconsistent bindings do not activate it.
- R7: The premises of a rule may be satisfied in any arrival order, including the last premise arriving after a stored partial match. A single fact may satisfy several premises of the same rule at once.
- R8: Bit i of `conflict_mask` is set when rule i is activated. Bits never clear except by reset, and the mask does not change while the block is idle.
- R9: Each alpha memory and each beta memory holds DEPTH entries (8). A new entry for a full memory is dropped and sets `overflow_err`, which stays set until reset. A dropped fact takes no part in later joins.
- R10: An active-low reset clears the configuration, all stored matches, `conflict_mask` and `overflow_err`, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Premise configuration write strobe |
| cfg_addr | input | 4 | {rule, premise} address of the write |
| cfg_wdata | input | 29 | Premise configuration word |
| fact_valid | input | 1 | A fact is offered |
| fact_ready | output | 1 | Block can take a fact |
| fact_pred | input | 8 | Predicate code of the fact |
| fact_arg0 | input | 8 | First argument of the fact |
| fact_arg1 | input | 8 | Second argument of the fact |
| match_done | output | 1 | One-cycle pulse when processing of a fact ends |
| conflict_mask | output | 4 | Sticky mask of activated rules |
| overflow_err | output | 1 | Sticky memory-overflow flag |

## Verification
The assertions assume that a sender honours the handshake: an offered fact stays stable until it is taken. They also assume that configuration writes happen only while the block is idle, because a premise rewritten during a join would change what the join sees. The stimulus follows both rules. Each fact is held from a falling edge until the edge that takes it, and the next fact is offered only after `match_done`. All configuration writes are issued right after reset, before the first fact. The variable values are chosen so that each join has exactly one expected outcome, and only the overflow scenario fills a memory.

// File: rtl/rete_match_pkg.sv
package rete_match_pkg;
  parameter int FW = 8;
  localparam int NPREM = 3;

  typedef enum logic [1:0] {
    ARG_CONST = 2'd0,
    ARG_VAR0  = 2'd1,
    ARG_VAR1  = 2'd2,
    ARG_ANY   = 2'd3
  } arg_kind_e;

  typedef struct packed {
    logic          en;
    logic [FW-1:0] pred;
    arg_kind_e     k0;
    logic [FW-1:0] c0;
    arg_kind_e     k1;
    logic [FW-1:0] c1;
  } prem_cfg_t;

  localparam int CFG_W = $bits(prem_cfg_t);

  typedef struct packed {
    logic          s0_ok;
    logic [FW-1:0] s0;
    logic          s1_ok;
    logic [FW-1:0] s1;
  } bind_t;

  function automatic logic bind_agree(bind_t a, bind_t b);
    return !(a.s0_ok && b.s0_ok && (a.s0 != b.s0)) &&
           !(a.s1_ok && b.s1_ok && (a.s1 != b.s1));
  endfunction

  function automatic bind_t bind_merge(bind_t a, bind_t b);
    bind_t m;
    m.s0_ok = a.s0_ok | b.s0_ok;
    m.s0    = a.s0_ok ? a.s0 : b.s0;
    m.s1_ok = a.s1_ok | b.s1_ok;
    m.s1    = a.s1_ok ? a.s1 : b.s1;
    return m;
  endfunction
endpackage

// File: rtl/rete_premise_test.sv
module rete_premise_test
  import rete_match_pkg::*;
(
  input  prem_cfg_t     cfg,
  input  logic [FW-1:0] pred,
  input  logic [FW-1:0] arg0,
  input  logic [FW-1:0] arg1,
  output logic          hit,
  output bind_t         bnd
);
  arg_kind_e     kind [2];
  logic [FW-1:0] cval [2];
  logic [FW-1:0] aval [2];

  assign kind[0] = cfg.k0;
  assign kind[1] = cfg.k1;
  assign cval[0] = cfg.c0;
  assign cval[1] = cfg.c1;
  assign aval[0] = arg0;
  assign aval[1] = arg1;

  always_comb begin
    bnd = '0;
    hit = cfg.en && (pred == cfg.pred);
    for (int i = 0; i < 2; i++) begin
      case (kind[i])
        ARG_CONST: if (aval[i] != cval[i]) hit = 1'b0;
        ARG_VAR0: begin
          if (bnd.s0_ok && (bnd.s0 != aval[i])) hit = 1'b0;
          bnd.s0_ok = 1'b1;
          bnd.s0    = aval[i];
        end
        ARG_VAR1: begin
          if (bnd.s1_ok && (bnd.s1 != aval[i])) hit = 1'b0;
          bnd.s1_ok = 1'b1;
          bnd.s1    = aval[i];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rete_rule_unit.sv
module rete_rule_unit
  import rete_match_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  prem_cfg_t [NPREM-1:0]  cfg,
  input  logic [FW-1:0]          f_pred,
  input  logic [FW-1:0]          f_arg0,
  input  logic [FW-1:0]          f_arg1,
  input  logic                   ph_load,
  input  logic                   ph_scan0,
  input  logic                   ph_scan1,
  input  logic [IW-1:0]          scan_idx,
  output logic                   fire,
  output logic                   ovf
);
  logic [NPREM-1:0] hit;
  bind_t            bnd [NPREM];
  bind_t            a_mem [NPREM][DEPTH];
  logic [CW-1:0]    a_cnt [NPREM];
  bind_t            b_mem [DEPTH];
  logic [CW-1:0]    b_cnt;
  logic             new0_ok;
  logic [IW-1:0]    new0_idx;
  logic [1:0]       npre;

  for (genvar k = 0; k < NPREM; k++) begin : g_test
    rete_premise_test u_test (
      .cfg (cfg[k]),
      .pred(f_pred),
      .arg0(f_arg0),
      .arg1(f_arg1),
      .hit (hit[k]),
      .bnd (bnd[k])
    );
  end

  always_comb begin
    if (!cfg[0].en)                     npre = 2'd0;
    else if (cfg[1].en && cfg[2].en)    npre = 2'd3;
    else if (cfg[1].en)                 npre = 2'd2;
    else                                npre = 2'd1;
  end

  logic  beta_any, a2_any, pair_ok, cons, beta_wr, a_full_hit;
  bind_t pa, pb, merged;

  always_comb begin
    beta_any = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if ((CW'(j) < b_cnt) && bind_agree(b_mem[j], bnd[2])) beta_any = 1'b1;

    pair_ok = 1'b0;
    pa = bnd[0];
    pb = bnd[1];
    if (ph_scan0) begin
      pair_ok = hit[0] && (CW'(scan_idx) < a_cnt[1]);
      pb      = a_mem[1][scan_idx];
    end else if (ph_scan1) begin
      pair_ok = hit[1] && (CW'(scan_idx) < a_cnt[0]) &&
                !(new0_ok && (scan_idx == new0_idx));
      pa      = a_mem[0][scan_idx];
    end
    merged = bind_merge(pa, pb);
    cons   = pair_ok && (npre >= 2'd2) && bind_agree(pa, pb);

    a2_any = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if ((CW'(j) < a_cnt[2]) && bind_agree(a_mem[2][j], merged)) a2_any = 1'b1;

    beta_wr = cons && (npre == 2'd3);

    a_full_hit = 1'b0;
    for (int k = 0; k < NPREM; k++)
      if (hit[k] && (a_cnt[k] == CW'(DEPTH))) a_full_hit = 1'b1;

    fire = (ph_load && (((npre == 2'd1) && hit[0]) ||
                        ((npre == 2'd3) && hit[2] && beta_any))) ||
           (cons && ((npre == 2'd2) || ((npre == 2'd3) && a2_any)));
    ovf  = (ph_load && a_full_hit) || (beta_wr && (b_cnt == CW'(DEPTH)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPREM; k++) a_cnt[k] <= '0;
      b_cnt    <= '0;
      new0_ok  <= 1'b0;
      new0_idx <= '0;
    end else begin
      if (ph_load) begin
        for (int k = 0; k < NPREM; k++)
          if (hit[k] && (a_cnt[k] != CW'(DEPTH))) begin
            a_mem[k][IW'(a_cnt[k])] <= bnd[k];
            a_cnt[k] <= a_cnt[k] + 1'b1;
          end
        new0_ok  <= hit[0] && (a_cnt[0] != CW'(DEPTH));
        new0_idx <= IW'(a_cnt[0]);
      end
      if (beta_wr && (b_cnt != CW'(DEPTH))) begin
        b_mem[IW'(b_cnt)] <= merged;
        b_cnt <= b_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rete_matcher.sv
module rete_matcher
  import rete_match_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int DEPTH     = 8,
  localparam int AW = $clog2(NUM_RULES) + 2,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 fact_valid,
  output logic                 fact_ready,
  input  logic [FW-1:0]        fact_pred,
  input  logic [FW-1:0]        fact_arg0,
  input  logic [FW-1:0]        fact_arg1,
  output logic                 match_done,
  output logic [NUM_RULES-1:0] conflict_mask,
  output logic                 overflow_err
);
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_SCAN0, ST_SCAN1, ST_DONE} state_e;

  state_e               state;
  logic [IW-1:0]        idx;
  logic [FW-1:0]        pred_q, arg0_q, arg1_q;
  prem_cfg_t [NPREM-1:0] cfg_q [NUM_RULES];
  logic [NUM_RULES-1:0] fire_v, ovf_v;

  assign fact_ready = (state == ST_IDLE);
  assign match_done = (state == ST_DONE);

  // Premise configuration store (R2, R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_RULES; r++) cfg_q[r] <= '0;
    end else if (cfg_we && (cfg_addr[1:0] != 2'd3) &&
                 (int'(cfg_addr[AW-1:2]) < NUM_RULES)) begin
      cfg_q[cfg_addr[AW-1:2]][cfg_addr[1:0]] <= prem_cfg_t'(cfg_wdata);
    end
  end

  // Sequencer: load alpha memories, then two join scans (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      pred_q <= '0;
      arg0_q <= '0;
      arg1_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (fact_valid) begin
          pred_q <= fact_pred;
          arg0_q <= fact_arg0;
          arg1_q <= fact_arg1;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          idx   <= '0;
          state <= ST_SCAN0;
        end
        ST_SCAN0: begin
          idx <= (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
          if (idx == IW'(DEPTH - 1)) state <= ST_SCAN1;
        end
        ST_SCAN1: begin
          idx <= (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
          if (idx == IW'(DEPTH - 1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    rete_rule_unit #(.DEPTH(DEPTH)) u_rule (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q[r]),
      .f_pred   (pred_q),
      .f_arg0   (arg0_q),
      .f_arg1   (arg1_q),
      .ph_load  (state == ST_LOAD),
      .ph_scan0 (state == ST_SCAN0),
      .ph_scan1 (state == ST_SCAN1),
      .scan_idx (idx),
      .fire     (fire_v[r]),
      .ovf      (ovf_v[r])
    );
  end

  // Sticky conflict mask (R8) and overflow flag (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conflict_mask <= '0;
      overflow_err  <= 1'b0;
    end else begin
      conflict_mask <= conflict_mask | fire_v;
      overflow_err  <= overflow_err | (|ovf_v);
    end
  end
endmodule

// File: rtl/rete_matcher_chk.sv
module rete_matcher_chk #(
  parameter int NUM_RULES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fact_valid,
  input logic                 fact_ready,
  input logic                 match_done,
  input logic [NUM_RULES-1:0] conflict_mask,
  input logic                 overflow_err
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fact_valid && fact_ready) |=> !fact_ready);

  assert_done_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    match_done |=> !match_done);

  assert_done_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    match_done |-> !fact_ready);

  assert_mask_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((conflict_mask & $past(conflict_mask)) == $past(conflict_mask)));

  assert_mask_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fact_ready |=> $stable(conflict_mask));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);
endmodule

bind rete_matcher rete_matcher_chk #(.NUM_RULES(NUM_RULES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fact_valid   (fact_valid),
  .fact_ready   (fact_ready),
  .match_done   (match_done),
  .conflict_mask(conflict_mask),
  .overflow_err (overflow_err)
);

// File: tb/rete_matcher_tb.sv
module rete_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [28:0] cfg_wdata = '0;
  logic        fact_valid = 1'b0;
  logic        fact_ready;
  logic [7:0]  fact_pred = '0, fact_arg0 = '0, fact_arg1 = '0;
  logic        match_done;
  logic [3:0]  conflict_mask;
  logic        overflow_err;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  rete_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fact_valid(fact_valid), .fact_ready(fact_ready),
    .fact_pred(fact_pred), .fact_arg0(fact_arg0), .fact_arg1(fact_arg1),
    .match_done(match_done), .conflict_mask(conflict_mask),
    .overflow_err(overflow_err)
  );

  localparam logic [1:0] K_C = 2'd0, K_V0 = 2'd1, K_V1 = 2'd2, K_ANY = 2'd3;

  function automatic logic [28:0] word(logic [7:0] p, logic [1:0] k0, logic [7:0] c0,
                                        logic [1:0] k1, logic [7:0] c1);
    return {1'b1, p, k0, c0, k1, c1};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(int rule, int prem, logic [28:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {rule[1:0], prem[1:0]};
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Driver: offers one fact, queues the expected mask, waits for completion
  task automatic send(logic [7:0] p, logic [7:0] a0, logic [7:0] a1,
                      logic [3:0] exp, string req, bit chk_lat = 1'b0);
    int lat = 0;
    @(negedge clk);
    fact_valid = 1'b1;
    fact_pred = p; fact_arg0 = a0; fact_arg1 = a1;
    while (!fact_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(posedge clk);
    @(negedge clk);
    fact_valid = 1'b0;
    lat = 1;
    while (!match_done) begin
      @(negedge clk);
      lat++;
    end
    if (chk_lat) check("R1 latency", lat, 18);
  endtask

  // Monitor: pops expected masks when the design reports a finished fact
  always @(negedge clk) begin
    if (rst_n && match_done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1: unexpected match_done, actual 1 expected 0");
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, conflict_mask, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R1 idle ready
    check("R10 mask", conflict_mask, 0);
    check("R10 err", overflow_err, 0);
    check("R1 ready", fact_ready, 1);
    check("R1 done", match_done, 0);

    // R2 configuration
    cfg_write(0, 0, word(8'h10, K_C, 8'h05, K_ANY, 8'h00));
    cfg_write(1, 0, word(8'h20, K_V0, 8'h00, K_V1, 8'h00));
    cfg_write(1, 1, word(8'h21, K_V1, 8'h00, K_C, 8'h07));
    cfg_write(2, 0, word(8'h30, K_V0, 8'h00, K_V1, 8'h00));
    cfg_write(2, 1, word(8'h31, K_V1, 8'h00, K_ANY, 8'h00));
    cfg_write(2, 2, word(8'h32, K_V0, 8'h00, K_C, 8'h09));
    cfg_write(3, 0, word(8'h40, K_V0, 8'h00, K_V0, 8'h00));
    cfg_write(0, 3, word(8'h10, K_ANY, 8'h00, K_ANY, 8'h00)); // R2 ignored slot

    send(8'h10, 8'h06, 8'h00, 4'b0000, "R3 const mismatch", 1'b1);
    send(8'h11, 8'h05, 8'h00, 4'b0000, "R3 pred mismatch");
    send(8'h10, 8'h05, 8'hAA, 4'b0001, "R5 single premise");
    send(8'h40, 8'h03, 8'h04, 4'b0001, "R4 same slot unequal");
    send(8'h40, 8'h03, 8'h03, 4'b1001, "R4 same slot equal");
    send(8'h21, 8'h08, 8'h07, 4'b1001, "R6 second premise stored");
    send(8'h20, 8'h01, 8'h09, 4'b1001, "R6 inconsistent join");
    send(8'h20, 8'h02, 8'h08, 4'b1011, "R6 consistent join");
    send(8'h32, 8'h0A, 8'h09, 4'b1011, "R7 third premise first");
    send(8'h31, 8'h0B, 8'h55, 4'b1011, "R7 second premise");
    send(8'h30, 8'h0C, 8'h0B, 4'b1011, "R7 partial match only");
    send(8'h30, 8'h0A, 8'h0B, 4'b1111, "R7 full match reverse order");

    do_reset();
    check("R10 mask after reset", conflict_mask, 0);
    cfg_write(0, 0, word(8'h50, K_V0, 8'h00, K_C, 8'h01));
    cfg_write(0, 1, word(8'h50, K_V0, 8'h00, K_ANY, 8'h00));
    cfg_write(2, 0, word(8'h30, K_V0, 8'h00, K_V1, 8'h00));
    cfg_write(2, 1, word(8'h31, K_V1, 8'h00, K_ANY, 8'h00));
    cfg_write(2, 2, word(8'h32, K_V0, 8'h00, K_C, 8'h09));
    send(8'h10, 8'h05, 8'h00, 4'b0000, "R10 config cleared");
    send(8'h50, 8'h33, 8'h01, 4'b0001, "R7 one fact two premises");
    send(8'h30, 8'h01, 8'h02, 4'b0001, "R7 first premise");
    send(8'h31, 8'h02, 8'h00, 4'b0001, "R7 beta stored");
    send(8'h32, 8'h01, 8'h09, 4'b0101, "R7 last premise vs beta");

    do_reset();
    cfg_write(3, 0, word(8'h60, K_V0, 8'h00, K_ANY, 8'h00));
    cfg_write(3, 1, word(8'h61, K_V0, 8'h00, K_ANY, 8'h00));
    for (int i = 1; i <= 8; i++)
      send(8'h60, 8'(i), 8'h00, 4'b0000, "R9 fill alpha");
    check("R9 no overflow at depth", overflow_err, 0);
    send(8'h60, 8'h09, 8'h00, 4'b0000, "R9 overflow entry");
    check("R9 overflow set", overflow_err, 1);
    send(8'h61, 8'h09, 8'h00, 4'b0000, "R9 dropped entry unused");
    send(8'h61, 8'h03, 8'h00, 4'b1000, "R9 stored entry joins");
    check("R9 overflow sticky", overflow_err, 1);

    repeat (4) @(negedge clk);
    check("R1 queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule